// File: doc/BRIEF.md
# Spread-Spectrum Dither Modulator

This block sits in front of a numerically controlled oscillator and bends its frequency control word so that the generated clock sweeps. Each sweep period starts at the programmed word. The word falls linearly to a selected depth below it and then climbs back. The radiated energy of the clock is spread over a band instead of sitting in one line. The deviation only ever subtracts, so the synthesized clock never runs faster than programmed.

A 3-bit code picks the depth and a 2-bit code picks how many master clock periods one triangle takes. Both codes are sampled only when the sweep is at its top, where the offset is zero, so a setting change never makes the word jump. With the spread control low, the nominal word passes straight through and the sweep restarts from the top when spreading resumes. The values below assume the default parameters (24-bit word, shortest period 2048 clocks, no fine correction).

Top module: `spread_dither_mod`

## Requirements
- R1: `fcw_out` never exceeds the nominal word sampled one clock earlier. At the bottom of each sweep it equals nominal minus the full depth D.
- R2: With unit U = (nom >> 8) + (nom >> 10), depth code 3'b000 gives D = U, 3'b001 gives 2U, 3'b010 gives 4U, 3'b100 gives 8U and 3'b111 gives 16U.
- R3: Depth codes 3'b011, 3'b101 and 3'b110 give D = 0, so the output stays at the nominal word.
- R4: Rate code 2'b00 makes the sweep period 8192 clocks, 2'b01 makes it 4096, and 2'b10 and 2'b11 both make it 2048. After P clocks the output is back at nominal.
- R5: While `spread_en` is low, the output one clock later equals the nominal word. The sweep position returns to the top, so the first word after re-enabling is the nominal word.
- R6: At step k of a period P with half length H = P/2, the offset is floor(D·k/H) for k up to H. On the way back it is floor(D·(P−k)/H).
- R7: A change of depth or rate code in mid-sweep has no effect until the sweep next passes its top. The current period completes with the old settings.
- R8: While reset is asserted the output is 0. The output is registered, so each input change shows one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | Enables the dither sweep |
| depth_sel | input | 3 | Depth code |
| rate_sel | input | 2 | Sweep period code |
| nom_fcw | input | FCW_W | Nominal frequency control word |
| fcw_out | output | FCW_W | Dithered frequency control word |

## Verification
The offset computed in a cycle is registered at the next edge. After spreading is enabled, the word seen after the m-th rising edge therefore belongs to sweep step m−1. The bench drives inputs on falling edges and counts falling edges from the enabling edge to reach an exact step. It checks steps H/2, H, P−1 and P, where the expected offsets D/2, D, D>>log2(H) and 0 separate depth, shape and period from each other. For setting changes, the bench counts on from the change through the rest of the old period to the first step of the new one.

// File: rtl/dither_pkg.sv
package dither_pkg;

   typedef struct packed {
      logic       on;
      logic [2:0] sh;
   } depth_dec_t;

   // depth code -> multiple of the 0.5% unit (as a left shift)
   function automatic depth_dec_t depth_decode(input logic [2:0] code);
      depth_dec_t d;
      unique case (code)
         3'b000:  d = '{on: 1'b1, sh: 3'd0};
         3'b001:  d = '{on: 1'b1, sh: 3'd1};
         3'b010:  d = '{on: 1'b1, sh: 3'd2};
         3'b100:  d = '{on: 1'b1, sh: 3'd3};
         3'b111:  d = '{on: 1'b1, sh: 3'd4};
         default: d = '{on: 1'b0, sh: 3'd0};
      endcase
      return d;
   endfunction

   // rate code -> log2 of the sweep period
   function automatic logic [5:0] period_log2(input logic [1:0] code,
                                              input int unsigned base_log2);
      unique case (code)
         2'b00:   return 6'(base_log2 + 2);
         2'b01:   return 6'(base_log2 + 1);
         default: return 6'(base_log2);
      endcase
   endfunction

endpackage

// File: rtl/dither_depth.sv
module dither_depth
   import dither_pkg::*;
#(
   parameter int unsigned FCW_W     = 24,
   parameter bit          FINE_CORR = 1'b0
) (
   input  logic [FCW_W-1:0] nom_fcw,
   input  logic [2:0]       depth_code,
   output logic [FCW_W-1:0] dmax
);

   logic [FCW_W-1:0] unit_dev;
   depth_dec_t       dec;

   generate
      if (FINE_CORR) begin : g_fine
         assign unit_dev = (nom_fcw >> 8) + (nom_fcw >> 10) + (nom_fcw >> 12);
      end else begin : g_coarse
         assign unit_dev = (nom_fcw >> 8) + (nom_fcw >> 10);
      end
   endgenerate

   always_comb begin
      dec  = depth_decode(depth_code);
      dmax = dec.on ? (unit_dev << dec.sh) : '0;
   end

endmodule

// File: rtl/dither_sweep.sv
module dither_sweep
   import dither_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 11,
   localparam int unsigned CNT_W    = BASE_LOG2 + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spread_en,
   input  logic [2:0]       depth_sel,
   input  logic [1:0]       rate_sel,
   output logic [CNT_W-1:0] step_k,
   output logic [5:0]       half_log2,
   output logic [2:0]       depth_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [1:0]       rate_q;
   logic [2:0]       depth_q;
   logic [1:0]       rate_eff;
   logic [5:0]       per_log2;
   logic [CNT_W-1:0] last_step;
   logic [CNT_W-1:0] mask;
   logic             at_top;

   assign at_top    = (cnt_q == '0);
   assign rate_eff  = at_top ? rate_sel  : rate_q;
   assign depth_o   = at_top ? depth_sel : depth_q;
   assign per_log2  = period_log2(rate_eff, BASE_LOG2);
   assign half_log2 = per_log2 - 6'd1;
   assign mask      = (CNT_W'(1) << per_log2) - CNT_W'(1);
   assign last_step = mask;

   // descending half: k = cnt; ascending half: k = P - cnt (= -cnt mod P)
   always_comb begin
      if (cnt_q <= (CNT_W'(1) << half_log2))
         step_k = cnt_q;
      else
         step_k = (-cnt_q) & mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rate_q  <= '0;
         depth_q <= '0;
      end else begin
         rate_q  <= rate_eff;
         depth_q <= depth_o;
         if (!spread_en)
            cnt_q <= '0;
         else if (cnt_q == last_step)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   a_r4_wrap_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (spread_en && cnt_q == last_step) |=> (cnt_q == '0));

   a_r7_cfg_held_mid_sweep: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(spread_en) && cnt_q != '0) |-> (depth_o == $past(depth_o) && half_log2 == $past(half_log2)));

   a_r5_restart_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      !spread_en |=> (cnt_q == '0));

endmodule

// File: rtl/dither_scale.sv
module dither_scale #(
   parameter int unsigned FCW_W = 24,
   parameter int unsigned CNT_W = 13,
   localparam int unsigned PW   = FCW_W + CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FCW_W-1:0] dmax,
   input  logic [CNT_W-1:0] step_k,
   input  logic [5:0]       half_log2,
   output logic [FCW_W-1:0] offset
);

   logic [PW-1:0] prod;

   assign prod   = PW'(dmax) * PW'(step_k);
   assign offset = FCW_W'(prod >> half_log2);

   a_r6_offset_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
      offset <= dmax);

endmodule

// File: rtl/spread_dither_mod.sv
module spread_dither_mod #(
   parameter int unsigned FCW_W     = 24,
   parameter int unsigned BASE_LOG2 = 11,
   parameter bit          FINE_CORR = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spread_en,
   input  logic [2:0]       depth_sel,
   input  logic [1:0]       rate_sel,
   input  logic [FCW_W-1:0] nom_fcw,
   output logic [FCW_W-1:0] fcw_out
);

   localparam int unsigned CNT_W = BASE_LOG2 + 2;

   generate
      if (FCW_W < 16) begin : g_bad_width
         $error("FCW_W must be at least 16");
      end
      if (BASE_LOG2 < 2 || BASE_LOG2 > 24) begin : g_bad_rate
         $error("BASE_LOG2 out of range");
      end
   endgenerate

   logic [CNT_W-1:0] step_k;
   logic [5:0]       half_log2;
   logic [2:0]       depth_code;
   logic [FCW_W-1:0] dmax;
   logic [FCW_W-1:0] offset;

   dither_sweep #(.BASE_LOG2(BASE_LOG2)) u_sweep (
      .clk       (clk),
      .rst_n     (rst_n),
      .spread_en (spread_en),
      .depth_sel (depth_sel),
      .rate_sel  (rate_sel),
      .step_k    (step_k),
      .half_log2 (half_log2),
      .depth_o   (depth_code)
   );

   dither_depth #(.FCW_W(FCW_W), .FINE_CORR(FINE_CORR)) u_depth (
      .nom_fcw    (nom_fcw),
      .depth_code (depth_code),
      .dmax       (dmax)
   );

   dither_scale #(.FCW_W(FCW_W), .CNT_W(CNT_W)) u_scale (
      .clk       (clk),
      .rst_n     (rst_n),
      .dmax      (dmax),
      .step_k    (step_k),
      .half_log2 (half_log2),
      .offset    (offset)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fcw_out <= '0;
      else if (spread_en)
         fcw_out <= nom_fcw - offset;
      else
         fcw_out <= nom_fcw;
   end

   a_r1_never_above_nominal: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fcw_out <= $past(nom_fcw)));

   a_r5_bypass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !spread_en |=> (fcw_out == $past(nom_fcw)));

endmodule

// File: tb/test_spread_dither_mod.sv
module test_spread_dither_mod;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 24;
   localparam int WATCHDOG   = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          spread_en = 1'b0;
   logic [2:0]    depth_sel = 3'b000;
   logic [1:0]    rate_sel = 2'b10;
   logic [W-1:0]  nom_fcw = '0;
   logic [W-1:0]  fcw_out;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   spread_dither_mod i_spread_dither_mod (
      .clk(clk), .rst_n(rst_n), .spread_en(spread_en),
      .depth_sel(depth_sel), .rate_sel(rate_sel),
      .nom_fcw(nom_fcw), .fcw_out(fcw_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // {depth, rate, nominal, expected full depth D}
   localparam int NV = 7;
   localparam logic [52:0] VEC [NV] = '{
      {3'b000, 2'b10, 24'h400000, 24'd20480},
      {3'b001, 2'b01, 24'h400000, 24'd40960},
      {3'b010, 2'b10, 24'h3A5C10, 24'd74700},
      {3'b100, 2'b11, 24'h400000, 24'd163840},
      {3'b111, 2'b00, 24'h7FFFFF, 24'd655328},
      {3'b011, 2'b10, 24'h400000, 24'd0},
      {3'b110, 2'b11, 24'h400000, 24'd0}
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int hlog_of(input logic [1:0] r);
      case (r)
         2'b00:   return 12;
         2'b01:   return 11;
         default: return 10;
      endcase
   endfunction

   function automatic logic [W-1:0] off_at(input longint d, input longint k, input int hl);
      return W'((d * k) >> hl);
   endfunction

   initial begin
      // R8: reset value
      wait_n(2);
      chk("R8 reset output", fcw_out, '0);
      nom_fcw = 24'h400000;
      rst_n = 1'b1;
      wait_n(1);
      chk("R8/R5 bypass one clock after reset", fcw_out, 24'h400000);
      nom_fcw = 24'h123456;
      wait_n(1);
      chk("R8 one clock latency", fcw_out, 24'h123456);

      // table of vectors: R1, R2, R3, R4, R6
      for (int i = 0; i < NV; i++) begin
         logic [2:0]   dv;
         logic [1:0]   rv;
         logic [W-1:0] nv;
         logic [W-1:0] ev;
         int           hl;
         int           h;
         {dv, rv, nv, ev} = VEC[i];
         hl = hlog_of(rv);
         h  = 1 << hl;
         @(negedge clk);
         spread_en = 1'b0; depth_sel = dv; rate_sel = rv; nom_fcw = nv;
         @(negedge clk);
         spread_en = 1'b1;
         wait_n(h/2 + 1);
         chk("R6 triangle mid-descent", fcw_out, nv - off_at(ev, h/2, hl));
         wait_n(h/2);
         chk((ev == 0) ? "R3 reserved code no dither" : "R1/R2 bottom equals nominal minus depth",
             fcw_out, nv - ev);
         wait_n(h - 1);
         chk("R4/R6 last step of period", fcw_out, nv - off_at(ev, 1, hl));
         wait_n(1);
         chk("R4 back at nominal after period", fcw_out, nv);
      end

      // R7: depth change mid-sweep waits for top
      @(negedge clk);
      spread_en = 1'b0; depth_sel = 3'b000; rate_sel = 2'b10; nom_fcw = 24'h400000;
      @(negedge clk);
      spread_en = 1'b1;
      wait_n(513);
      depth_sel = 3'b111;
      wait_n(512);
      chk("R7 old depth kept to end of sweep", fcw_out, 24'h400000 - 24'd20480);
      wait_n(1024);
      chk("R7 top of sweep", fcw_out, 24'h400000);
      wait_n(1024);
      chk("R7 new depth after top", fcw_out, 24'h400000 - 24'd327680);

      // R7: rate change mid-sweep waits for top
      @(negedge clk);
      spread_en = 1'b0; depth_sel = 3'b001; rate_sel = 2'b10;
      @(negedge clk);
      spread_en = 1'b1;
      wait_n(513);
      rate_sel = 2'b00;
      wait_n(1535);
      chk("R7 old period kept", fcw_out, 24'h400000 - 24'd40);
      wait_n(1);
      chk("R7 top reached at old period", fcw_out, 24'h400000);
      wait_n(2048);
      chk("R7 new period slope", fcw_out, 24'h400000 - 24'd20480);

      // R5: disable mid-sweep, restart from top
      @(negedge clk);
      spread_en = 1'b0; depth_sel = 3'b111; rate_sel = 2'b10;
      @(negedge clk);
      spread_en = 1'b1;
      wait_n(300);
      spread_en = 1'b0;
      wait_n(1);
      chk("R5 disabled gives nominal", fcw_out, 24'h400000);
      spread_en = 1'b1;
      wait_n(1);
      chk("R5 restart at top", fcw_out, 24'h400000);
      wait_n(1024);
      chk("R5 full sweep after restart", fcw_out, 24'h400000 - 24'd327680);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule